// File: doc/BRIEF.md
# Table-Indirect Call and Return Sequencer

This block runs the control steps of a call made through a table of halfword offsets, and of the return that matches it. A call instruction carries a six-bit slot number. The sequencer does four things in order. It keeps the address of the following instruction and the current status word in two save registers set aside for this kind of call. It forms the table address from a base value and the slot number. It fetches the 16-bit offset stored at that address. It then redirects the program counter to the base plus that offset.

The return instruction takes two halfwords. When it is seen, the block writes the saved program counter and the saved status word back in a single cycle.

The host core supplies the instruction halfwords, its program counter, its status word and the table base. It watches `busy` so that it can hold off further work while a sequence is running. The core then applies the `pc_load` and `psw_load` pulses, together with the values that come with them. Table reads go out over a halfword request port, and that port may add wait cycles of any length by keeping `rd_valid` low.

Top module: `tblcall_seq`

## Requirements
- R1: Reset state. After reset, all of these are 0: `busy`, `rd_req`, `pc_load`, `psw_load`, `save_pc` and `save_psw`.
- R2: Call recognition and saving. The call is recognised only while the block is idle, when `insn_valid` is high and `insn_hw0[15:6]` equals `0000001000`. The slot number is `insn_hw0[5:0]`. From the second busy cycle on, `save_pc` holds `cur_pc+2` and `save_psw` holds `cur_psw`, both taken at the cycle the call was accepted.
- R3: Table request. In the third busy cycle `rd_req` goes high. At the same time `rd_addr` equals the accepted base plus the zero-extended slot number shifted left by one, modulo 2^AW.
- R4: Read wait. While `rd_req` is high and `rd_valid` is low, the block holds three things unchanged: `rd_req` stays high, `rd_addr` stays the same and `busy` stays high. `rd_data` is ignored until `rd_valid` is high.
- R5: Call target. In the cycle after the read completes, `pc_load` pulses for exactly one cycle. With it, `pc_next` equals the base plus the zero-extended `rd_data`, modulo 2^AW, with bit 0 cleared.
- R6: Call length. With no wait cycles, `busy` stays high for exactly 4 cycles. Each cycle that `rd_valid` is held low adds one more busy cycle. `busy` falls in the cycle after the `pc_load` pulse.
- R7: Return. The block is idle and `insn_valid` is high with `insn_hw0 = 16'h07E0` and `insn_hw1 = 16'h0144`. It then spends one busy cycle in which `pc_load` and `psw_load` are both high, `pc_next` equals `save_pc` and `psw_next` equals `save_psw`.
- R8: Ignored instructions. Any instruction presented while `busy` is high has no effect on the running sequence or on the save registers. An instruction matching neither encoding raises neither `busy` nor any load.
- R9: A call never asserts `psw_load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| insn_valid | input | 1 | Instruction halfwords are valid |
| insn_hw0 | input | 16 | First instruction halfword |
| insn_hw1 | input | 16 | Second instruction halfword |
| cur_pc | input | AW | Program counter of the presented instruction |
| cur_psw | input | PW | Current status word |
| tbl_base | input | AW | Table base value |
| rd_req | output | 1 | Table read request |
| rd_addr | output | AW | Table read address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 16 | Read halfword |
| pc_load | output | 1 | Load `pc_next` into the program counter |
| pc_next | output | AW | New program counter |
| psw_load | output | 1 | Load `psw_next` into the status word |
| psw_next | output | PW | New status word |
| busy | output | 1 | A sequence is in progress |
| save_pc | output | AW | Saved return address |
| save_psw | output | PW | Saved status word |

## Verification
The bench builds the block with AW=16 and PW=8. The 16-bit address makes wraparound easy to reach: a base near the top of the space wraps both the table address and the jump target. With PW=8, distinct status patterns such as 5A, A5 and FF show up clearly in the saved and restored values. The vectors cover slot 0 and slot 63, an odd base, an odd offset and the largest offset. They also cover zero, one and two read wait cycles.

// File: rtl/tblcall_pkg.sv
package tblcall_pkg;

    // Slot number width is fixed by the call encoding.
    localparam int IDX_W = 6;
    localparam logic [9:0]  CALL_OPC = 10'b0000001000;
    localparam logic [15:0] RET_HW0  = 16'h07E0;
    localparam logic [15:0] RET_HW1  = 16'h0144;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SAVE = 3'd1,
        ST_ADDR = 3'd2,
        ST_LOAD = 3'd3,
        ST_JUMP = 3'd4,
        ST_RET  = 3'd5
    } seq_st_e;

endpackage

// File: rtl/tblcall_decode.sv
module tblcall_decode
    import tblcall_pkg::*;
(
    input  logic [15:0]      hw0,
    input  logic [15:0]      hw1,
    output logic             is_call,
    output logic             is_ret,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        is_call = (hw0[15:IDX_W] == CALL_OPC);
        is_ret  = (hw0 == RET_HW0) && (hw1 == RET_HW1);
        idx     = hw0[IDX_W-1:0];
    end

endmodule

// File: rtl/tblcall_addr.sv
module tblcall_addr
    import tblcall_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]    base,
    input  logic [IDX_W-1:0] idx,
    input  logic [15:0]      data,
    output logic [AW-1:0]    tbl_addr,
    output logic [AW-1:0]    target
);

    // AW must be at least 16 so the offset fits without truncation.
    localparam int SLOT_W = IDX_W + 1;

    logic [SLOT_W-1:0] slot_bytes;
    logic [AW-1:0]     sum;

    always_comb begin
        slot_bytes = {idx, 1'b0};
        tbl_addr   = base + AW'(slot_bytes);
        sum        = base + AW'(data);
        target     = {sum[AW-1:1], 1'b0};
    end

endmodule

// File: rtl/tblcall_save.sv
module tblcall_save #(
    parameter int AW = 32,
    parameter int PW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] pc_in,
    input  logic [PW-1:0] psw_in,
    output logic [AW-1:0] save_pc,
    output logic [PW-1:0] save_psw
);

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [PW-1:0] psw;
    } save_t;

    save_t sv_d, sv_q;

    always_comb begin
        sv_d = sv_q;
        if (we) begin
            sv_d.pc  = pc_in;
            sv_d.psw = psw_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sv_q <= '0;
        else        sv_q <= sv_d;
    end

    assign save_pc  = sv_q.pc;
    assign save_psw = sv_q.psw;

endmodule

// File: rtl/tblcall_seq.sv
module tblcall_seq
    import tblcall_pkg::*;
#(
    parameter int AW = 32,
    parameter int PW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          insn_valid,
    input  logic [15:0]   insn_hw0,
    input  logic [15:0]   insn_hw1,
    input  logic [AW-1:0] cur_pc,
    input  logic [PW-1:0] cur_psw,
    input  logic [AW-1:0] tbl_base,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_valid,
    input  logic [15:0]   rd_data,
    output logic          pc_load,
    output logic [AW-1:0] pc_next,
    output logic          psw_load,
    output logic [PW-1:0] psw_next,
    output logic          busy,
    output logic [AW-1:0] save_pc,
    output logic [PW-1:0] save_psw
);

    localparam logic [AW-1:0] INSN_BYTES = AW'(2);

    typedef struct packed {
        seq_st_e          st;
        logic [IDX_W-1:0] idx;
        logic [AW-1:0]    base;
        logic [AW-1:0]    ret_pc;
        logic [PW-1:0]    psw;
        logic [AW-1:0]    addr;
        logic [AW-1:0]    tgt;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic             dec_call, dec_ret;
    logic [IDX_W-1:0] dec_idx;
    logic [AW-1:0]    calc_addr, calc_tgt;
    logic             save_we;

    tblcall_decode u_dec (
        .hw0     (insn_hw0),
        .hw1     (insn_hw1),
        .is_call (dec_call),
        .is_ret  (dec_ret),
        .idx     (dec_idx)
    );

    tblcall_addr #(.AW(AW)) u_addr (
        .base     (ctx_q.base),
        .idx      (ctx_q.idx),
        .data     (rd_data),
        .tbl_addr (calc_addr),
        .target   (calc_tgt)
    );

    tblcall_save #(.AW(AW), .PW(PW)) u_save (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (save_we),
        .pc_in    (ctx_q.ret_pc),
        .psw_in   (ctx_q.psw),
        .save_pc  (save_pc),
        .save_psw (save_psw)
    );

    always_comb begin
        ctx_d   = ctx_q;
        save_we = 1'b0;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (insn_valid && dec_call) begin
                    ctx_d.st     = ST_SAVE;
                    ctx_d.idx    = dec_idx;
                    ctx_d.base   = tbl_base;
                    ctx_d.ret_pc = cur_pc + INSN_BYTES;
                    ctx_d.psw    = cur_psw;
                end else if (insn_valid && dec_ret) begin
                    ctx_d.st = ST_RET;
                end
            end
            ST_SAVE: begin
                save_we  = 1'b1;
                ctx_d.st = ST_ADDR;
            end
            ST_ADDR: begin
                ctx_d.addr = calc_addr;
                ctx_d.st   = ST_LOAD;
            end
            ST_LOAD: begin
                if (rd_valid) begin
                    ctx_d.tgt = calc_tgt;
                    ctx_d.st  = ST_JUMP;
                end
            end
            ST_JUMP: ctx_d.st = ST_IDLE;
            ST_RET:  ctx_d.st = ST_IDLE;
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    always_comb begin
        busy     = (ctx_q.st != ST_IDLE);
        rd_req   = (ctx_q.st == ST_LOAD);
        rd_addr  = ctx_q.addr;
        psw_load = (ctx_q.st == ST_RET);
        pc_load  = (ctx_q.st == ST_JUMP) || psw_load;
        pc_next  = psw_load ? save_pc : ctx_q.tgt;
        psw_next = save_psw;
    end

endmodule

// File: rtl/tblcall_seq_chk.sv
module tblcall_seq_chk #(
    parameter int AW = 32,
    parameter int PW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          rd_req,
    input logic          rd_valid,
    input logic [AW-1:0] rd_addr,
    input logic          pc_load,
    input logic [AW-1:0] pc_next,
    input logic          psw_load,
    input logic [PW-1:0] psw_next,
    input logic [AW-1:0] save_pc,
    input logic [PW-1:0] save_psw
);

    // R3
    req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> busy);

    // R4
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> (rd_req && busy && $stable(rd_addr)));

    // R5
    target_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && !psw_load) |-> !pc_next[0]);

    // R5
    load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !pc_load);

    // R6
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && !psw_load) |=> !busy);

    // R7
    ret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psw_load |-> (pc_next == save_pc && psw_next == save_psw && busy));

    // R9
    psw_only_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psw_load |-> pc_load);

endmodule

bind tblcall_seq tblcall_seq_chk #(.AW(AW), .PW(PW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .rd_req   (rd_req),
    .rd_valid (rd_valid),
    .rd_addr  (rd_addr),
    .pc_load  (pc_load),
    .pc_next  (pc_next),
    .psw_load (psw_load),
    .psw_next (psw_next),
    .save_pc  (save_pc),
    .save_psw (save_psw)
);

// File: tb/tblcall_seq_test.sv
`timescale 1ns/1ps
module tblcall_seq_test;

    localparam int AW = 16;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          insn_valid = 1'b0;
    logic [15:0]   insn_hw0 = '0;
    logic [15:0]   insn_hw1 = '0;
    logic [AW-1:0] cur_pc = '0;
    logic [PW-1:0] cur_psw = '0;
    logic [AW-1:0] tbl_base = '0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_valid = 1'b0;
    logic [15:0]   rd_data = '0;
    logic          pc_load;
    logic [AW-1:0] pc_next;
    logic          psw_load;
    logic [PW-1:0] psw_next;
    logic          busy;
    logic [AW-1:0] save_pc;
    logic [PW-1:0] save_psw;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    tblcall_seq #(.AW(AW), .PW(PW)) uut (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_hw0(insn_hw0),
        .insn_hw1(insn_hw1), .cur_pc(cur_pc), .cur_psw(cur_psw), .tbl_base(tbl_base),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .pc_load(pc_load), .pc_next(pc_next), .psw_load(psw_load), .psw_next(psw_next),
        .busy(busy), .save_pc(save_pc), .save_psw(save_psw)
    );

    typedef struct packed {
        logic [5:0]  idx;
        logic [15:0] base;
        logic [15:0] pc;
        logic [7:0]  psw;
        logic [15:0] data;
        logic [3:0]  waits;
        logic [15:0] exp_addr;
        logic [15:0] exp_tgt;
        logic [15:0] exp_spc;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{6'd0,  16'h1000, 16'h0200, 8'h5A, 16'h0040, 4'd0, 16'h1000, 16'h1040, 16'h0202},
        '{6'd63, 16'h2000, 16'h0FFE, 8'hA5, 16'h0123, 4'd2, 16'h207E, 16'h2122, 16'h1000},
        '{6'd5,  16'hFFF0, 16'hFFFE, 8'h01, 16'h0020, 4'd0, 16'hFFFA, 16'h0010, 16'h0000},
        '{6'd32, 16'h8001, 16'h1234, 8'hFF, 16'hFFFF, 4'd1, 16'h8041, 16'h8000, 16'h1236}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_call(input vec_t v, input bit noise);
        @(negedge clk);
        insn_valid = 1'b1;
        insn_hw0   = {10'b0000001000, v.idx};
        cur_pc     = v.pc;
        cur_psw    = v.psw;
        tbl_base   = v.base;
        @(negedge clk);
        if (noise) begin
            // R8: another call with different operands while busy
            insn_hw0 = {10'b0000001000, ~v.idx};
            cur_pc   = v.pc + 16'h0100;
            cur_psw  = ~v.psw;
            tbl_base = v.base + 16'h0400;
        end else begin
            insn_valid = 1'b0;
        end
        chk("R6 busy cycle1", 32'(busy), 32'd1);
        @(negedge clk);
        chk("R2 save_pc", 32'(save_pc), 32'(v.exp_spc));
        chk("R2 save_psw", 32'(save_psw), 32'(v.psw));
        chk("R3 no early req", 32'(rd_req), 32'd0);
        @(negedge clk);
        chk("R3 rd_req", 32'(rd_req), 32'd1);
        chk("R3 rd_addr", 32'(rd_addr), 32'(v.exp_addr));
        for (int w = 0; w < int'(v.waits); w++) begin
            rd_valid = 1'b0;
            rd_data  = ~v.data;
            @(negedge clk);
            chk("R4 req held", 32'({rd_req, busy, pc_load}), 32'b110);
            chk("R4 addr held", 32'(rd_addr), 32'(v.exp_addr));
        end
        rd_valid = 1'b1;
        rd_data  = v.data;
        @(negedge clk);
        rd_valid = 1'b0;
        rd_data  = 16'hDEAD;
        chk("R5 pc_load", 32'(pc_load), 32'd1);
        chk("R5 pc_next", 32'(pc_next), 32'(v.exp_tgt));
        chk("R9 psw_load", 32'(psw_load), 32'd0);
        chk("R6 busy at jump", 32'(busy), 32'd1);
        insn_valid = 1'b0;
        @(negedge clk);
        chk("R6 busy end", 32'(busy), 32'd0);
        chk("R5 pulse end", 32'(pc_load), 32'd0);
        if (noise) begin
            chk("R8 save_pc kept", 32'(save_pc), 32'(v.exp_spc));
            chk("R8 save_psw kept", 32'(save_psw), 32'(v.psw));
        end
    endtask

    task automatic do_ret(input logic [15:0] exp_pc, input logic [7:0] exp_psw);
        @(negedge clk);
        insn_valid = 1'b1;
        insn_hw0   = 16'h07E0;
        insn_hw1   = 16'h0144;
        @(negedge clk);
        insn_valid = 1'b0;
        insn_hw1   = 16'h0000;
        chk("R7 loads", 32'({pc_load, psw_load, busy}), 32'b111);
        chk("R7 pc_next", 32'(pc_next), 32'(exp_pc));
        chk("R7 psw_next", 32'(psw_next), 32'(exp_psw));
        @(negedge clk);
        chk("R7 one cycle", 32'({pc_load, psw_load, busy}), 32'b000);
    endtask

    task automatic do_junk(input logic [15:0] h0, input logic [15:0] h1, input string tag);
        @(negedge clk);
        insn_valid = 1'b1;
        insn_hw0   = h0;
        insn_hw1   = h1;
        @(negedge clk);
        insn_valid = 1'b0;
        chk(tag, 32'({busy, pc_load, psw_load, rd_req}), 32'b0000);
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ctl", 32'({busy, rd_req, pc_load, psw_load}), 32'b0000);
        chk("R1 save", 32'({save_pc, save_psw}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", 32'(busy), 32'd0);

        for (int i = 0; i < 4; i++) begin
            do_call(VECS[i], 1'b0);
            do_ret(VECS[i].exp_spc, VECS[i].psw);
        end

        // R8: instructions arriving while busy are ignored
        do_call(VECS[1], 1'b1);
        do_ret(VECS[1].exp_spc, VECS[1].psw);

        // R8: encodings that match neither instruction
        do_junk(16'h0240, 16'h0000, "R8 near call opcode");
        do_junk(16'h07E0, 16'h0145, "R8 bad return hw1");
        do_junk(16'h07E1, 16'h0144, "R8 bad return hw0");
        chk("R8 save after junk", 32'(save_pc), 32'(VECS[1].exp_spc));

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule